// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the control state for one 32-pin general-purpose I/O bank behind a simple memory-mapped read/write bus. It keeps three registers: output data, direction and output enable. It also gives a read-only view of the external pin levels, which pass through a two-flop synchronizer first. The pad drive signals come from these registers. A pin is enabled only when both its direction bit and its output-enable bit are 1. The driven level is the output data bit gated by that enable.

Software never writes the output data register as a whole. Instead it uses two write-only half-word ports, one for the lower 16 pins and one for the upper 16. Each port takes a 32-bit word whose upper half is a per-bit mask and whose lower half is the data. A cleared mask bit lets its data bit through, and a set mask bit keeps the old output value. One pin, or any group of pins within a half, can therefore change in a single bus write with no read-modify-write sequence. Two pins of the bank, 7 and 8, cannot be inputs: their direction bits are fixed at 1.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the output data, direction and output-enable registers are zero. The direction register reads 0x0000_0180, because pins 7 and 8 are fixed outputs. pin_oe and pin_out are all zero.
- R2: A write to offset 0x000 (lower port) takes the mask in wdata[31:16] and the data in wdata[15:0]. For each i in 0..15, output bit i takes data bit i when mask bit i is 0 and keeps its value when mask bit i is 1.
- R3: A write to the lower port never changes output bits 31:16.
- R4: A write to offset 0x004 (upper port) uses the same word layout. Output bit 16+i takes data bit i when mask bit i is 0, and output bits 15:0 never change.
- R5: A read of offset 0x000 or 0x004 returns zero.
- R6: The direction register at offset 0x204 is read/write, and a bit value of 1 selects an output.
- R7: Direction bits 7 and 8 always read as 1 and act as 1. Writing 0 to them has no effect.
- R8: The output-enable register at offset 0x208 is read/write.
- R9: pin_oe equals direction AND output enable, bit by bit. pin_out equals the output data AND pin_oe.
- R10: A read of offset 0x060 returns pin_in as it was two clock edges earlier, through a two-flop synchronizer. Writes to 0x060 have no effect.
- R11: A write takes effect on the clock edge where bus_wen is high. bus_rdata carries the read data in the cycle after bus_ren and is zero otherwise. An unmapped offset reads as zero.
- R12: A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_ren |
| pin_in | input | 32 | External pin levels (asynchronous) |
| pin_out | output | 32 | Level driven to each pad |
| pin_oe | output | 32 | Pad drive enable per pin |

## Verification
A bus read and a bus write can fall in the same cycle and target the same register, so read selection and register update are active together. The bench raises bus_wen and bus_ren in one cycle at the output-enable offset. It expects the value from before the write in the following cycle, and the new value on a later read. The masked-write merge also takes part in every output update. Mixed mask patterns in both halves are judged at pin_out with all pins enabled.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned BUS_ADDR_W = 12;

    localparam logic [BUS_ADDR_W-1:0] OFS_MASK_LO = 12'h000;
    localparam logic [BUS_ADDR_W-1:0] OFS_MASK_HI = 12'h004;
    localparam logic [BUS_ADDR_W-1:0] OFS_PIN_IN  = 12'h060;
    localparam logic [BUS_ADDR_W-1:0] OFS_DIR     = 12'h204;
    localparam logic [BUS_ADDR_W-1:0] OFS_OUT_EN  = 12'h208;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ZERO,
        SEL_PIN_IN,
        SEL_DIR,
        SEL_OUT_EN
    } rd_sel_e;

    function automatic rd_sel_e decode_read(input logic [BUS_ADDR_W-1:0] a);
        rd_sel_e s;
        case (a)
            OFS_MASK_LO, OFS_MASK_HI: s = SEL_ZERO;
            OFS_PIN_IN:               s = SEL_PIN_IN;
            OFS_DIR:                  s = SEL_DIR;
            OFS_OUT_EN:               s = SEL_OUT_EN;
            default:                  s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_merge.sv
module gpio_mask_merge #(
    parameter int unsigned HALF_W = 16
) (
    input  logic [HALF_W-1:0]   cur_bits,
    input  logic [2*HALF_W-1:0] wr_word,
    output logic [HALF_W-1:0]   new_bits
);
    logic [HALF_W-1:0] keep_mask;
    logic [HALF_W-1:0] data_bits;

    assign keep_mask = wr_word[2*HALF_W-1:HALF_W];
    assign data_bits = wr_word[HALF_W-1:0];
    assign new_bits  = (cur_bits & keep_mask) | (data_bits & ~keep_mask);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned        NUM_PINS    = 32,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter logic [NUM_PINS-1:0] FIXED_OUTS = 32'h0000_0180
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wen,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    input  logic                  bus_ren,
    output logic [NUM_PINS-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe
);
    localparam int unsigned HALF_W  = NUM_PINS / 2;
    localparam int unsigned N_HALVES = 2;

    typedef struct packed {
        logic [NUM_PINS-1:0] dout;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] outen;
        logic [NUM_PINS-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_PINS-1:0] pins_sync;
    logic [NUM_PINS-1:0] dir_eff;
    logic [HALF_W-1:0]   merged [N_HALVES];
    logic [N_HALVES-1:0] half_hit;

    gpio_sync_stage #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    assign half_hit[0] = bus_wen && (bus_addr == OFS_MASK_LO);
    assign half_hit[1] = bus_wen && (bus_addr == OFS_MASK_HI);

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        gpio_mask_merge #(.HALF_W(HALF_W)) u_merge (
            .cur_bits (state_q.dout[h*HALF_W +: HALF_W]),
            .wr_word  (bus_wdata),
            .new_bits (merged[h])
        );
    end

    assign dir_eff = state_q.dir | FIXED_OUTS;

    always_comb begin
        state_d = state_q;

        for (int h = 0; h < N_HALVES; h++) begin
            if (half_hit[h]) state_d.dout[h*HALF_W +: HALF_W] = merged[h];
        end

        if (bus_wen && bus_addr == OFS_DIR)    state_d.dir   = bus_wdata;
        if (bus_wen && bus_addr == OFS_OUT_EN) state_d.outen = bus_wdata;

        state_d.rdata = '0;
        if (bus_ren) begin
            case (decode_read(bus_addr))
                SEL_PIN_IN: state_d.rdata = pins_sync;
                SEL_DIR:    state_d.rdata = dir_eff;
                SEL_OUT_EN: state_d.rdata = state_q.outen;
                default:    state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata = state_q.rdata;
    assign pin_oe    = dir_eff & state_q.outen;
    assign pin_out   = state_q.dout & pin_oe;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BUS_ADDR_W-1:0] bus_addr,
    input logic                  bus_wen,
    input logic [NUM_PINS-1:0]   bus_wdata,
    input logic                  bus_ren,
    input logic [NUM_PINS-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic [NUM_PINS-1:0]   dout_q,
    input logic [NUM_PINS-1:0]   outen_q
);
    localparam int unsigned HALF_W = NUM_PINS / 2;

    a_r1_reset_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0));

    a_r3_lower_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_MASK_LO) |=> $stable(dout_q[NUM_PINS-1:HALF_W]));

    a_r4_upper_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_MASK_HI) |=> $stable(dout_q[HALF_W-1:0]));

    a_r2_mask_holds_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFS_MASK_LO) |=>
        ((dout_q[HALF_W-1:0] & $past(bus_wdata[NUM_PINS-1:HALF_W])) ==
         ($past(dout_q[HALF_W-1:0]) & $past(bus_wdata[NUM_PINS-1:HALF_W]))));

    a_r5_masked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && (bus_addr == OFS_MASK_LO || bus_addr == OFS_MASK_HI)) |=> (bus_rdata == '0));

    a_r7_fixed_pins_follow_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[8:7] == outen_q[8:7]);

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> (bus_rdata == '0));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .dout_q    (state_q.dout),
    .outen_q   (state_q.outen)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_bank_regs u_gpio_bank_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        bus_ren = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1 pin_oe after reset", pin_oe, 32'h0);
        chk("R1 pin_out after reset", pin_out, 32'h0);
        bus_read(12'h204, r); chk("R1 direction reset", r, 32'h0000_0180);
        bus_read(12'h208, r); chk("R1 output enable reset", r, 32'h0);
        @(negedge clk);
        chk("R11 rdata zero when idle", bus_rdata, 32'h0);
    endtask

    task automatic t_masked_writes();
        bus_write(12'h204, 32'hFFFF_FFFF);
        bus_write(12'h208, 32'hFFFF_FFFF);
        bus_write(12'h000, 32'h0000_A5A5);
        chk("R2 lower full write", pin_out, 32'h0000_A5A5);
        bus_write(12'h000, 32'hFF00_1234);
        chk("R2 lower partial mask", pin_out, 32'h0000_A534);
        bus_write(12'h004, 32'h0000_BEEF);
        chk("R4 upper full write", pin_out, 32'hBEEF_A534);
        bus_write(12'h004, 32'h00FF_0000);
        chk("R4 upper partial mask", pin_out, 32'h00EF_A534);
        bus_write(12'h000, 32'hFFFF_0000);
        chk("R3 all-masked lower write keeps all", pin_out, 32'h00EF_A534);
    endtask

    task automatic t_masked_read_zero();
        logic [31:0] r;
        bus_read(12'h000, r); chk("R5 lower port reads zero", r, 32'h0);
        bus_read(12'h004, r); chk("R5 upper port reads zero", r, 32'h0);
    endtask

    task automatic t_direction();
        logic [31:0] r;
        bus_write(12'h204, 32'h0F0F_0000);
        bus_read(12'h204, r); chk("R6 direction readback", r, 32'h0F0F_0180);
        bus_write(12'h204, 32'h0);
        bus_read(12'h204, r); chk("R7 fixed direction bits", r, 32'h0000_0180);
        chk("R9 pin_oe with fixed outputs", pin_oe, 32'h0000_0180);
        chk("R7 fixed pins still drive", pin_out, 32'h0000_0100);
    endtask

    task automatic t_outen();
        logic [31:0] r;
        bus_write(12'h204, 32'hFFFF_FFFF);
        bus_write(12'h208, 32'h0000_00F0);
        bus_read(12'h208, r); chk("R8 output enable readback", r, 32'h0000_00F0);
        chk("R9 pin_oe gated", pin_oe, 32'h0000_00F0);
        chk("R9 pin_out gated", pin_out, 32'h0000_0030);
    endtask

    task automatic t_pin_in();
        logic [31:0] r;
        @(negedge clk);
        pin_in = 32'hCAFE_1234;
        @(negedge clk);
        @(negedge clk);
        bus_read(12'h060, r); chk("R10 synchronized pins", r, 32'hCAFE_1234);
        bus_write(12'h060, 32'h0);
        bus_read(12'h060, r); chk("R10 write to data-in ignored", r, 32'hCAFE_1234);
        chk("R10 write to data-in leaves pins", pin_out, 32'h0000_0030);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        bus_read(12'h100, r); chk("R11 unmapped reads zero", r, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] r;
        @(negedge clk);
        bus_addr = 12'h208; bus_wdata = 32'h0F0F_0F0F;
        bus_wen = 1'b1; bus_ren = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_ren = 1'b0;
        chk("R12 same-cycle read returns old", bus_rdata, 32'h0000_00F0);
        bus_read(12'h208, r); chk("R12 later read returns new", r, 32'h0F0F_0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_writes();
        t_masked_read_zero();
        t_direction();
        t_outen();
        t_pin_in();
        t_unmapped();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule